// File: doc/BRIEF.md
# Serial Programming Command Shifter

This block is the device-side serial port used while a part sits in program/verify mode. An external host toggles a slow serial clock and presents data on a single data line. The block samples that line on every falling serial-clock edge, least significant bit first. Each frame is twenty bits long: a four-bit opcode followed by a sixteen-bit operand. Both serial lines are resynchronised to the system clock, so the serial clock only needs to be slow relative to `clk_i`.

Depending on the opcode, a finished frame does one of three things. It hands the operand to the processor core as an instruction. It issues a table write to memory with the operand as data. Or, for read-type opcodes, it fetches a byte into an eight-bit table latch and turns the data line around so that the byte is driven back during the last eight operand clocks. A 22-bit table pointer supplies the memory address. It can step up or down by one (before or after the access) or advance by two after a write. The core can overwrite it through a load port.

Top module: `prog_ser_shifter`

## Requirements
- R1: The data line is sampled on each falling edge of `pgc_i` while `prog_en_i` is high. The first four bits of a frame form the opcode and the next sixteen form the operand, each sent least significant bit first.
- R2: Opcode 0000 raises `core_valid_o` for one cycle after the twentieth falling edge, with the operand on `core_instr_o`.
- R3: Opcode 1000 issues one `mem_rd_o` pulse at the pointer once the opcode is complete and leaves the pointer unchanged. The byte on `mem_rdata_i` in the following cycle becomes the table latch, and the latch is driven on `pgd_o` least significant bit first, one bit per serial clock, over operand clocks 9 to 16.
- R4: Opcode 1001 reads at the pointer, then increments the pointer by one.
- R5: Opcode 1010 reads at the pointer, then decrements the pointer by one.
- R6: Opcode 1011 increments the pointer by one and reads at the new value.
- R7: Opcode 0010 drives the current table latch out as in R3 without issuing any memory read.
- R8: Opcode 1100 issues one `mem_wr_o` pulse at the pointer, with the operand on `mem_wdata_o` and `mem_prog_o` low, and leaves the pointer unchanged.
- R9: Opcode 1101 writes as in R8, then advances the pointer by two. Opcode 1111 does the same with `mem_prog_o` high during the write pulse.
- R10: `pgd_oe_o` is high only during operand clocks 9 to 16 of opcodes 0010 and 1000 to 1011. It is low at every other time.
- R11: Opcodes 0001, 0011 to 0111 and 1110 consume a full frame and produce no strobe and no pointer change. The next frame is still decoded correctly.
- R12: While `prog_en_i` is low, the bit count returns to the start of a frame and `pgd_oe_o` goes low. After reset, all strobes are low, `pgd_oe_o` is low and the pointer is zero.
- R13: `ptr_load_i` sets the pointer to `ptr_load_val_i` in the next cycle. All pointer arithmetic wraps modulo 2^22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_en_i | input | 1 | Program/verify mode active; low re-aligns framing |
| pgc_i | input | 1 | Serial clock from the host |
| pgd_i | input | 1 | Serial data from the host |
| pgd_o | output | 1 | Serial data driven back to the host |
| pgd_oe_o | output | 1 | Output enable for the data line |
| core_valid_o | output | 1 | One-cycle strobe: instruction for the core |
| core_instr_o | output | 16 | Instruction word for the core |
| ptr_load_i | input | 1 | Core loads the table pointer |
| ptr_load_val_i | input | 22 | Value for the pointer load |
| ptr_o | output | 22 | Current table pointer |
| mem_rd_o | output | 1 | One-cycle memory read request |
| mem_wr_o | output | 1 | One-cycle memory write request |
| mem_prog_o | output | 1 | Write also starts programming |
| mem_addr_o | output | 22 | Address of the read or write request |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 8 | Read byte, valid the cycle after `mem_rd_o` |

## Verification
The hardest state to reach from the ports is a loss of mode while the block is driving the data line. In that case output enable, framing and the next frame must all recover together. The stimulus starts a read frame, stops after two output bits with `pgd_oe_o` confirmed high, and drops `prog_en_i`. It then checks that the line is released and that a following core frame decodes cleanly. Pointer wrap is reached by loading zero through the core port, then issuing a post-decrement read and a step-by-two write. This walks the pointer across the top of the 22-bit range in both directions.

// File: rtl/prog_ser_pkg.sv
package prog_ser_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_CORE      = 4'b0000,
    CMD_LATCH_OUT = 4'b0010,
    CMD_RD        = 4'b1000,
    CMD_RD_PINC   = 4'b1001,
    CMD_RD_PDEC   = 4'b1010,
    CMD_RD_PREINC = 4'b1011,
    CMD_WR        = 4'b1100,
    CMD_WR_INC2   = 4'b1101,
    CMD_WR_PROG   = 4'b1111
  } ser_cmd_e;

  typedef enum logic [1:0] {
    PTR_HOLD,
    PTR_INC1,
    PTR_DEC1,
    PTR_INC2
  } ptr_op_e;

  function automatic logic cmd_is_read(input logic [CMD_W-1:0] c);
    return c inside {CMD_RD, CMD_RD_PINC, CMD_RD_PDEC, CMD_RD_PREINC};
  endfunction

  function automatic logic cmd_is_tx(input logic [CMD_W-1:0] c);
    return cmd_is_read(c) || (c == CMD_LATCH_OUT);
  endfunction

  function automatic logic cmd_is_write(input logic [CMD_W-1:0] c);
    return c inside {CMD_WR, CMD_WR_INC2, CMD_WR_PROG};
  endfunction
endpackage

// File: rtl/ser_edge_sync.sv
module ser_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pgc_i,
  input  logic pgd_i,
  output logic rise_o,
  output logic fall_o,
  output logic data_o
);
  logic [STAGES-1:0] pgc_sr, pgd_sr;
  logic              pgc_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pgc_sr <= '0;
      pgd_sr <= '0;
      pgc_d  <= 1'b0;
    end else begin
      pgc_sr <= {pgc_sr[STAGES-2:0], pgc_i};
      pgd_sr <= {pgd_sr[STAGES-2:0], pgd_i};
      pgc_d  <= pgc_sr[STAGES-1];
    end
  end

  assign rise_o = pgc_sr[STAGES-1] & ~pgc_d;
  assign fall_o = ~pgc_sr[STAGES-1] & pgc_d;
  // data is aligned with the clock pipeline, so it is still stable at the fall
  assign data_o = pgd_sr[STAGES-1];
endmodule

// File: rtl/ser_frame.sv
module ser_frame
  import prog_ser_pkg::*;
#(
  parameter int OPD_W     = 16,
  parameter int FRAME_LEN = CMD_W + OPD_W,
  parameter int CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fall_i,
  input  logic             data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             cmd_evt_o,
  output logic [OPD_W-1:0] opnd_o,
  output logic             frame_evt_o
);
  localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN - 1);

  logic [FRAME_LEN-1:0] sh_q;
  logic [CNT_W-1:0]     cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q        <= '0;
      cnt_q       <= '0;
      cmd_o       <= '0;
      opnd_o      <= '0;
      cmd_evt_o   <= 1'b0;
      frame_evt_o <= 1'b0;
    end else begin
      cmd_evt_o   <= 1'b0;
      frame_evt_o <= 1'b0;
      if (!en_i) begin
        cnt_q <= '0;
      end else if (fall_i) begin
        sh_q <= {data_i, sh_q[FRAME_LEN-1:1]};
        if (cnt_q == CNT_CMD) begin
          cmd_o     <= {data_i, sh_q[FRAME_LEN-1:FRAME_LEN-CMD_W+1]};
          cmd_evt_o <= 1'b1;
        end
        if (cnt_q == CNT_LAST) begin
          cnt_q       <= '0;
          opnd_o      <= {data_i, sh_q[FRAME_LEN-1:CMD_W+1]};
          frame_evt_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);  // R1
  AST_EN_REALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);  // R12
endmodule

// File: rtl/ser_tblptr.sv
module ser_tblptr
  import prog_ser_pkg::*;
#(
  parameter int PTR_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_val_i,
  input  ptr_op_e          op_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [PTR_W-1:0] ptr_inc_o
);
  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (load_i) begin
      ptr_q <= load_val_i;
    end else begin
      unique case (op_i)
        PTR_INC1: ptr_q <= ptr_q + PTR_W'(1);
        PTR_DEC1: ptr_q <= ptr_q - PTR_W'(1);
        PTR_INC2: ptr_q <= ptr_q + PTR_W'(2);
        default:  ptr_q <= ptr_q;
      endcase
    end
  end

  assign ptr_o     = ptr_q;
  assign ptr_inc_o = ptr_q + PTR_W'(1);

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && op_i == PTR_HOLD) |=> $stable(ptr_q));  // R11
  AST_PTR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ptr_q == $past(load_val_i));  // R13
endmodule

// File: rtl/ser_latch_tx.sv
module ser_latch_tx #(
  parameter int LAT_W     = 8,
  parameter int FRAME_LEN = 20,
  parameter int CNT_W     = $clog2(FRAME_LEN),
  parameter int IDX_W     = $clog2(LAT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tx_cmd_i,
  input  logic             rd_i,
  input  logic [LAT_W-1:0] rdata_i,
  output logic             pgd_o,
  output logic             oe_o
);
  localparam logic [CNT_W-1:0] CNT_TX   = CNT_W'(FRAME_LEN - LAT_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN - 1);

  logic [LAT_W-1:0] lat_q;
  logic             rd_q;
  logic             in_win;
  logic [IDX_W-1:0] idx;

  assign in_win = (cnt_i >= CNT_TX);
  assign idx    = IDX_W'(cnt_i - CNT_TX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      rd_q  <= 1'b0;
      pgd_o <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      rd_q <= rd_i;
      if (rd_q) lat_q <= rdata_i;
      if (!en_i || (fall_i && cnt_i == CNT_LAST)) begin
        oe_o <= 1'b0;
      end else if (rise_i && tx_cmd_i && in_win) begin
        oe_o  <= 1'b1;
        pgd_o <= lat_q[idx];
      end
    end
  end

  AST_OE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> in_win);  // R10
endmodule

// File: rtl/prog_ser_shifter.sv
module prog_ser_shifter
  import prog_ser_pkg::*;
#(
  parameter int PTR_W       = 22,
  parameter int OPD_W       = 16,
  parameter int LAT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prog_en_i,
  input  logic             pgc_i,
  input  logic             pgd_i,
  output logic             pgd_o,
  output logic             pgd_oe_o,
  output logic             core_valid_o,
  output logic [OPD_W-1:0] core_instr_o,
  input  logic             ptr_load_i,
  input  logic [PTR_W-1:0] ptr_load_val_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             mem_prog_o,
  output logic [PTR_W-1:0] mem_addr_o,
  output logic [OPD_W-1:0] mem_wdata_o,
  input  logic [LAT_W-1:0] mem_rdata_i
);
  localparam int FRAME_LEN = CMD_W + OPD_W;
  localparam int CNT_W     = $clog2(FRAME_LEN);

  logic             rise, fall, sdata;
  logic [CNT_W-1:0] cnt;
  logic [CMD_W-1:0] cmd;
  logic             cmd_evt, frame_evt;
  logic [OPD_W-1:0] opnd;
  logic [PTR_W-1:0] ptr, ptr_inc;
  ptr_op_e          ptr_op;

  ser_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .pgc_i, .pgd_i,
    .rise_o(rise), .fall_o(fall), .data_o(sdata)
  );

  ser_frame #(.OPD_W(OPD_W), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) i_frame (
    .clk_i, .rst_ni, .en_i(prog_en_i), .fall_i(fall), .data_i(sdata),
    .cnt_o(cnt), .cmd_o(cmd), .cmd_evt_o(cmd_evt),
    .opnd_o(opnd), .frame_evt_o(frame_evt)
  );

  always_comb begin
    ptr_op = PTR_HOLD;
    if (cmd_evt) begin
      unique case (cmd)
        CMD_RD_PINC, CMD_RD_PREINC: ptr_op = PTR_INC1;
        CMD_RD_PDEC:                ptr_op = PTR_DEC1;
        default:                    ptr_op = PTR_HOLD;
      endcase
    end else if (frame_evt && (cmd == CMD_WR_INC2 || cmd == CMD_WR_PROG)) begin
      ptr_op = PTR_INC2;
    end
  end

  ser_tblptr #(.PTR_W(PTR_W)) i_ptr (
    .clk_i, .rst_ni, .load_i(ptr_load_i), .load_val_i(ptr_load_val_i),
    .op_i(ptr_op), .ptr_o(ptr), .ptr_inc_o(ptr_inc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_valid_o <= 1'b0;
      core_instr_o <= '0;
      mem_rd_o     <= 1'b0;
      mem_wr_o     <= 1'b0;
      mem_prog_o   <= 1'b0;
      mem_addr_o   <= '0;
      mem_wdata_o  <= '0;
    end else begin
      core_valid_o <= 1'b0;
      mem_rd_o     <= 1'b0;
      mem_wr_o     <= 1'b0;
      mem_prog_o   <= 1'b0;
      if (cmd_evt && cmd_is_read(cmd)) begin
        mem_rd_o   <= 1'b1;
        mem_addr_o <= (cmd == CMD_RD_PREINC) ? ptr_inc : ptr;
      end
      if (frame_evt) begin
        if (cmd == CMD_CORE) begin
          core_valid_o <= 1'b1;
          core_instr_o <= opnd;
        end else if (cmd_is_write(cmd)) begin
          mem_wr_o    <= 1'b1;
          mem_prog_o  <= (cmd == CMD_WR_PROG);
          mem_addr_o  <= ptr;
          mem_wdata_o <= opnd;
        end
      end
    end
  end

  ser_latch_tx #(.LAT_W(LAT_W), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) i_tx (
    .clk_i, .rst_ni, .en_i(prog_en_i), .rise_i(rise), .fall_i(fall),
    .cnt_i(cnt), .tx_cmd_i(cmd_is_tx(cmd)), .rd_i(mem_rd_o),
    .rdata_i(mem_rdata_i), .pgd_o, .oe_o(pgd_oe_o)
  );

  assign ptr_o = ptr;

  AST_STROBE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({core_valid_o, mem_rd_o, mem_wr_o}));  // R2
  AST_PROG_WITH_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_prog_o |-> mem_wr_o);  // R9
  AST_RD_BEFORE_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> !pgd_oe_o);  // R3
  AST_OE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prog_en_i) |=> !pgd_oe_o);  // R12
endmodule

// File: tb/test_prog_ser_shifter.sv
module test_prog_ser_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_en = 1'b0;
  logic        pgc = 1'b0;
  logic        pgd = 1'b0;
  logic        pgd_o, pgd_oe;
  logic        core_valid;
  logic [15:0] core_instr;
  logic        ptr_load = 1'b0;
  logic [21:0] ptr_load_val = '0;
  logic [21:0] ptr;
  logic        mem_rd, mem_wr, mem_prog;
  logic [21:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [7:0]  mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int          kind;   // 0 core, 1 read, 2 write
    logic [21:0] addr;
    logic [15:0] data;
    logic        prog;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  prog_ser_shifter i_prog_ser_shifter (
    .clk_i(clk), .rst_ni(rst_n), .prog_en_i(prog_en), .pgc_i(pgc), .pgd_i(pgd),
    .pgd_o(pgd_o), .pgd_oe_o(pgd_oe), .core_valid_o(core_valid),
    .core_instr_o(core_instr), .ptr_load_i(ptr_load), .ptr_load_val_i(ptr_load_val),
    .ptr_o(ptr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_prog_o(mem_prog),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] mem_f(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h96;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= mem_f(mem_addr);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int kind, input logic [21:0] addr, input logic [15:0] data,
                      input logic prog, input string req);
    exp_t e;
    e.kind = kind; e.addr = addr; e.data = data; e.prog = prog; e.req = req;
    sb.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && (core_valid || mem_rd || mem_wr)) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected strobe act=%0b%0b%0b exp=000", core_valid, mem_rd, mem_wr);
      end else begin
        exp_t e;
        int   k;
        e = sb.pop_front();
        k = core_valid ? 0 : (mem_rd ? 1 : 2);
        check({e.req, " kind"}, 32'(k), 32'(e.kind));
        if (e.kind == 0) check({e.req, " instr"}, 32'(core_instr), 32'(e.data));
        else check({e.req, " addr"}, 32'(mem_addr), 32'(e.addr));
        if (e.kind == 2) begin
          check({e.req, " wdata"}, 32'(mem_wdata), 32'(e.data));
          check({e.req, " prog"}, 32'(mem_prog), 32'(e.prog));
        end
      end
    end
  end

  task automatic send_frame(input logic [3:0] cmd, input logic [15:0] opnd, input logic tx,
                            input logic [7:0] lat_exp, input string req, input int nbits = 20);
    logic [7:0] rx = '0;
    int         oe_bad = 0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      pgc = 1'b1;
      pgd = (i < 4) ? cmd[i] : ((tx && i >= 12) ? 1'b0 : opnd[i-4]);
      repeat (8) @(negedge clk);
      if (pgd_oe !== (tx && i >= 12)) oe_bad++;
      if (i >= 12) rx[i-12] = pgd_o;
      pgc = 1'b0;
      repeat (8) @(negedge clk);
    end
    check({req, " R10 oe window"}, 32'(oe_bad), 0);
    if (tx && nbits == 20) check({req, " tx data"}, 32'(rx), 32'(lat_exp));
  endtask

  task automatic load_ptr(input logic [21:0] v);
    @(negedge clk);
    ptr_load = 1'b1; ptr_load_val = v;
    @(negedge clk);
    ptr_load = 1'b0;
    check("R13 load", 32'(ptr), 32'(v));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset oe", 32'(pgd_oe), 0);
    check("R12 reset ptr", 32'(ptr), 0);
    check("R12 reset strobes", {29'd0, core_valid, mem_rd, mem_wr}, 0);
    prog_en = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2: core instruction, asymmetric pattern exposes bit order
    push(0, '0, 16'hA5C3, 1'b0, "R2");
    send_frame(4'b0000, 16'hA5C3, 1'b0, 8'h00, "R1");

    load_ptr(22'h012345);
    push(1, 22'h012345, '0, 1'b0, "R3");
    send_frame(4'b1000, 16'hFFFF, 1'b1, mem_f(22'h012345), "R3");
    check("R3 ptr", 32'(ptr), 32'h012345);

    push(1, 22'h012345, '0, 1'b0, "R4");
    send_frame(4'b1001, 16'h0000, 1'b1, mem_f(22'h012345), "R4");
    check("R4 ptr", 32'(ptr), 32'h012346);

    push(1, 22'h012346, '0, 1'b0, "R5");
    send_frame(4'b1010, 16'h0000, 1'b1, mem_f(22'h012346), "R5");
    check("R5 ptr", 32'(ptr), 32'h012345);

    push(1, 22'h012346, '0, 1'b0, "R6");
    send_frame(4'b1011, 16'h0000, 1'b1, mem_f(22'h012346), "R6");
    check("R6 ptr", 32'(ptr), 32'h012346);

    send_frame(4'b0010, 16'h0000, 1'b1, mem_f(22'h012346), "R7");
    check("R7 ptr", 32'(ptr), 32'h012346);

    push(2, 22'h012346, 16'hBEEF, 1'b0, "R8");
    send_frame(4'b1100, 16'hBEEF, 1'b0, 8'h00, "R8");
    check("R8 ptr", 32'(ptr), 32'h012346);

    push(2, 22'h012346, 16'h1234, 1'b0, "R9");
    send_frame(4'b1101, 16'h1234, 1'b0, 8'h00, "R9");
    check("R9 ptr", 32'(ptr), 32'h012348);

    push(2, 22'h012348, 16'h5678, 1'b1, "R9");
    send_frame(4'b1111, 16'h5678, 1'b0, 8'h00, "R9");
    check("R9 prog ptr", 32'(ptr), 32'h01234A);

    send_frame(4'b0101, 16'hFFFF, 1'b0, 8'h00, "R11");
    send_frame(4'b1110, 16'hAAAA, 1'b0, 8'h00, "R11");
    send_frame(4'b0001, 16'h0F0F, 1'b0, 8'h00, "R11");
    check("R11 ptr", 32'(ptr), 32'h01234A);
    push(0, '0, 16'hC001, 1'b0, "R11");
    send_frame(4'b0000, 16'hC001, 1'b0, 8'h00, "R11");

    // R13 wrap in both directions
    load_ptr(22'h000000);
    push(1, 22'h000000, '0, 1'b0, "R13");
    send_frame(4'b1010, 16'h0000, 1'b1, mem_f(22'h000000), "R13");
    check("R13 wrap down", 32'(ptr), 32'h3FFFFF);
    push(2, 22'h3FFFFF, 16'h0102, 1'b0, "R13");
    send_frame(4'b1101, 16'h0102, 1'b0, 8'h00, "R13");
    check("R13 wrap up", 32'(ptr), 32'h000001);

    // R12: drop mode while the line is driven
    push(1, 22'h000001, '0, 1'b0, "R12");
    send_frame(4'b1000, 16'h0000, 1'b1, 8'h00, "R12", 14);
    @(negedge clk);
    prog_en = 1'b0;
    repeat (4) @(negedge clk);
    check("R12 oe released", 32'(pgd_oe), 0);
    prog_en = 1'b1;
    repeat (4) @(negedge clk);
    push(0, '0, 16'h8001, 1'b0, "R12");
    send_frame(4'b0000, 16'h8001, 1'b0, 8'h00, "R12");

    repeat (10) @(negedge clk);
    check("R11 scoreboard drained", 32'(sb.size()), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule